// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control unit and register set of a small accumulator machine. It carries each instruction through a fixed series of subcycles: fetch, then an optional indirect step, then execute, then an optional interrupt entry. Every memory access goes through two architectural registers. An address register drives the memory address bus. A buffer register captures read data and supplies write data. The program counter and the instruction register are updated only in fixed, named steps.

The memory is external, has a single port, and returns read data one cycle after the read strobe. An interrupt request line is honoured only when the interrupt-enable flag is set. On entry, the block saves the program counter at a fixed save location and jumps to a fixed handler address. The execute subcycle supports load, store, add, jump, return-from-interrupt and enable-interrupts. Zero and sign flags follow the accumulator. A two-bit subcycle output shows which subcycle is active.

Top module: `isc_sequencer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, PC, accumulator, zero flag, sign flag and interrupt enable are all 0, both strobes are low, and the subcycle output reads 0.
- R2: Subcycle codes are fetch=0, indirect=1, execute=2, interrupt=3. Fetch lasts four cycles. In the second cycle the read strobe is high and the address bus carries PC. PC shows PC+1 from the third fetch cycle onwards.
- R3: An instruction word has the opcode in bits 15:13, the indirect flag in bit 12 and the address field in bits 11:0. The opcodes are 0 load, 1 store, 2 add, 3 jump, 4 return, 5 enable interrupts. Opcodes 6 and 7 do nothing.
- R4: When bit 12 is set, fetch is followed by three indirect cycles. The second of these reads the address field. The low 12 bits of the returned word become the effective address. When bit 12 is clear, the effective address is the address field.
- R5: Load and add take four execute cycles. The read strobe is high in the second cycle with the effective address on the bus. The accumulator takes the new value after the fourth cycle. Add wraps modulo 2^16.
- R6: Zero (result is 0) and sign (bit 15 of the result) are updated only by load and add. All other instructions leave them unchanged.
- R7: Store takes two execute cycles. In the second cycle the write strobe is high, the address bus carries the effective address and the data bus carries the accumulator.
- R8: Jump takes one execute cycle and loads PC with the effective address.
- R9: Enable-interrupts and the no-op opcodes take one execute cycle. Enable-interrupts sets the interrupt-enable flag. The no-ops change no state.
- R10: The interrupt request is sampled only in the last execute cycle of an instruction. The interrupt is taken only if the interrupt-enable flag was set before that instruction ran. A request seen at any other time, or with the flag clear, has no effect.
- R11: Interrupt entry takes three cycles with subcycle 3. In the third cycle, PC (zero-extended) is written to the save location. PC then becomes the handler address and interrupt enable is cleared. The next fetch reads from the handler address.
- R12: Return takes four execute cycles. It reads the save location in the second cycle, then loads PC from the low 12 bits of the word read and sets interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Maskable interrupt request |
| mem_rdata | input | 16 | Read data, valid one cycle after the read strobe |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |
| ie_out | output | 1 | Interrupt-enable flag |
| zero_out | output | 1 | Zero flag |
| sign_out | output | 1 | Sign flag |
| subcycle | output | 2 | Active subcycle code |

## Verification
The sequencer runs one program that uses every opcode, both direct and indirect, including an indirect store and an indirect jump. It also runs a handler that adds, stores and returns. A load followed by an add of its negation reaches a zero result, and adding 0x8000 turns on the sign flag. These tell the flag updates apart from the plain accumulator transfer. The interrupt request is driven in several patterns: a window while the enable flag is still clear, a long window that includes instruction ends, single-cycle pulses that fall mid-instruction, and a window during the idle jump loop. These separate correct sampling at the instruction end from sampling at the wrong time and from ignoring the enable flag. A cycle-accurate behavioural model is compared with the bus, the strobes and the visible registers on every cycle.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_JUMP  = 3'd3,
    OP_RET   = 3'd4,
    OP_EI    = 3'd5,
    OP_NOP6  = 3'd6,
    OP_NOP7  = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    S_F_ADDR, S_F_RD, S_F_CAP, S_F_IR,
    S_I_ADDR, S_I_RD, S_I_CAP,
    S_X_ADDR, S_X_RD, S_X_CAP, S_X_ALU, S_X_WR,
    S_N_SAVE, S_N_ADDR, S_N_WR
  } phase_e;

  typedef enum logic [1:0] {
    SUB_FETCH = 2'd0,
    SUB_IND   = 2'd1,
    SUB_EXEC  = 2'd2,
    SUB_INTR  = 2'd3
  } subcycle_e;

  function automatic subcycle_e subcycle_of(phase_e p);
    case (p)
      S_F_ADDR, S_F_RD, S_F_CAP, S_F_IR: return SUB_FETCH;
      S_I_ADDR, S_I_RD, S_I_CAP:         return SUB_IND;
      S_N_SAVE, S_N_ADDR, S_N_WR:        return SUB_INTR;
      default:                           return SUB_EXEC;
    endcase
  endfunction
endpackage

// File: rtl/isc_ctrl.sv
`timescale 1ns/1ps
module isc_ctrl
  import isc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    irq,
  input  logic    ie,
  input  logic    fetched_ind,
  input  opcode_e op,
  output phase_e  phase
);
  logic   done;
  phase_e phase_nxt;

  // last execute cycle of the current instruction
  always_comb begin
    done = 1'b0;
    case (phase)
      S_X_ADDR: done = (op == OP_JUMP) || (op == OP_EI) ||
                       (op == OP_NOP6) || (op == OP_NOP7);
      S_X_ALU, S_X_WR: done = 1'b1;
      default: done = 1'b0;
    endcase
  end

  always_comb begin
    phase_nxt = phase;
    case (phase)
      S_F_ADDR: phase_nxt = S_F_RD;
      S_F_RD:   phase_nxt = S_F_CAP;
      S_F_CAP:  phase_nxt = S_F_IR;
      S_F_IR:   phase_nxt = fetched_ind ? S_I_ADDR : S_X_ADDR;
      S_I_ADDR: phase_nxt = S_I_RD;
      S_I_RD:   phase_nxt = S_I_CAP;
      S_I_CAP:  phase_nxt = S_X_ADDR;
      S_X_ADDR: begin
        if (op == OP_STORE)
          phase_nxt = S_X_WR;
        else if ((op == OP_LOAD) || (op == OP_ADD) || (op == OP_RET))
          phase_nxt = S_X_RD;
      end
      S_X_RD:   phase_nxt = S_X_CAP;
      S_X_CAP:  phase_nxt = S_X_ALU;
      S_N_SAVE: phase_nxt = S_N_ADDR;
      S_N_ADDR: phase_nxt = S_N_WR;
      S_N_WR:   phase_nxt = S_F_ADDR;
      default:  phase_nxt = S_F_ADDR;
    endcase
    if (done) phase_nxt = (irq && ie) ? S_N_SAVE : S_F_ADDR;
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= S_F_ADDR;
    else     phase <= phase_nxt;
  end

  // R10: interrupt entry only follows a cycle with request and enable both high
  a_r10_entry_gated: assert property (@(posedge clk) disable iff (rst)
    (phase == S_N_SAVE) |-> ($past(ie) && $past(irq)));

  // R4: the indirect capture cycle comes two cycles after the indirect address cycle
  a_r4_indirect_order: assert property (@(posedge clk) disable iff (rst)
    (phase == S_I_CAP) |-> ($past(phase, 2) == S_I_ADDR));
endmodule

// File: rtl/isc_acc.sv
`timescale 1ns/1ps
module isc_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_load,
  input  logic              do_add,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic              zero,
  output logic              sign
);
  logic [DATA_W-1:0] result;

  always_comb begin
    result = acc;
    if (do_load)     result = operand;
    else if (do_add) result = acc + operand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      zero <= 1'b0;
      sign <= 1'b0;
    end else if (do_load || do_add) begin
      acc  <= result;
      zero <= (result == '0);
      sign <= result[DATA_W-1];
    end
  end

  // R6: after an update the flags describe the new accumulator
  a_r6_flags_follow: assert property (@(posedge clk) disable iff (rst)
    (do_load || do_add) |=> ((zero == (acc == '0)) && (sign == acc[DATA_W-1])));

  // R6: without an update the flags hold
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !(do_load || do_add) |=> ($stable(zero) && $stable(sign)));
endmodule

// File: rtl/isc_datapath.sv
`timescale 1ns/1ps
module isc_datapath
  import isc_pkg::*;
#(
  parameter int               DATA_W       = 16,
  parameter int               ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h3FE,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] pc,
  output opcode_e           op,
  output logic              fetched_ind,
  output logic              ie,
  output logic [DATA_W-1:0] operand,
  output logic              alu_load,
  output logic              alu_add
);
  localparam int               IND_BIT = ADDR_W;
  localparam int               EXT_W   = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  opcode_e           ir;
  logic [ADDR_W-1:0] ea;

  assign ea          = mbr[ADDR_W-1:0];
  assign op          = ir;
  assign fetched_ind = mbr[IND_BIT];
  assign operand     = mbr;
  assign mem_addr    = mar;
  assign mem_wdata   = mbr;
  assign mem_rd      = (phase == S_F_RD) || (phase == S_I_RD) || (phase == S_X_RD);
  assign mem_wr      = (phase == S_X_WR) || (phase == S_N_WR);
  assign alu_load    = (phase == S_X_ALU) && (ir == OP_LOAD);
  assign alu_add     = (phase == S_X_ALU) && (ir == OP_ADD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= OP_LOAD;
      ie  <= 1'b0;
    end else begin
      case (phase)
        S_F_ADDR: mar <= pc;
        S_F_RD:   pc  <= pc + PC_ONE;
        S_F_CAP, S_I_CAP, S_X_CAP: mbr <= mem_rdata;
        S_F_IR:   ir  <= opcode_e'(mbr[DATA_W-1 -: OP_W]);
        S_I_ADDR: mar <= ea;
        S_X_ADDR: begin
          case (ir)
            OP_LOAD, OP_ADD: mar <= ea;
            OP_STORE: begin
              mar <= ea;
              mbr <= acc;
            end
            OP_RET:  mar <= SAVE_ADDR;
            OP_JUMP: pc  <= ea;
            OP_EI:   ie  <= 1'b1;
            default: ;
          endcase
        end
        S_X_ALU: begin
          if (ir == OP_RET) begin
            pc <= ea;
            ie <= 1'b1;
          end
        end
        S_N_SAVE: mbr <= {{EXT_W{1'b0}}, pc};
        S_N_ADDR: mar <= SAVE_ADDR;
        S_N_WR: begin
          pc <= HANDLER_ADDR;
          ie <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R2: the fetch read cycle advances PC by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (phase == S_F_RD) |=> (pc == $past(pc) + PC_ONE));

  // R11: the save write targets the save location with the current PC
  a_r11_save_write: assert property (@(posedge clk) disable iff (rst)
    (phase == S_N_WR) |-> (mem_wr && (mem_addr == SAVE_ADDR) &&
                           (mem_wdata == {{EXT_W{1'b0}}, pc})));

  // R11: after entry PC is the handler and interrupts are masked
  a_r11_vector: assert property (@(posedge clk) disable iff (rst)
    (phase == S_N_WR) |=> ((pc == HANDLER_ADDR) && !ie));

  // R9/R12: the enable flag rises only from enable-interrupts or return
  a_r9_ie_source: assert property (@(posedge clk) disable iff (rst)
    $rose(ie) |-> (($past(phase) == S_X_ADDR) || ($past(phase) == S_X_ALU)));

  // R2: read and write strobes never overlap
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

// File: rtl/isc_sequencer.sv
`timescale 1ns/1ps
module isc_sequencer #(
  parameter int               DATA_W       = 16,
  parameter int               ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h3FE,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] acc_out,
  output logic              ie_out,
  output logic              zero_out,
  output logic              sign_out,
  output logic [1:0]        subcycle
);
  import isc_pkg::*;

  phase_e            phase;
  opcode_e           op;
  logic              fetched_ind;
  logic              ie;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] acc;
  logic              alu_load;
  logic              alu_add;

  isc_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .ie          (ie),
    .fetched_ind (fetched_ind),
    .op          (op),
    .phase       (phase)
  );

  isc_datapath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .acc         (acc),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .pc          (pc_out),
    .op          (op),
    .fetched_ind (fetched_ind),
    .ie          (ie),
    .operand     (operand),
    .alu_load    (alu_load),
    .alu_add     (alu_add)
  );

  isc_acc #(.DATA_W(DATA_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .do_load (alu_load),
    .do_add  (alu_add),
    .operand (operand),
    .acc     (acc),
    .zero    (zero_out),
    .sign    (sign_out)
  );

  assign acc_out  = acc;
  assign ie_out   = ie;
  assign subcycle = subcycle_of(phase);
endmodule

// File: tb/isc_sequencer_tb.sv
`timescale 1ns/1ps
module isc_sequencer_tb;
  localparam int          NCYC = 700;
  localparam logic [11:0] SAVE = 12'h3FE;
  localparam logic [11:0] HND  = 12'h100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [11:0] mem_addr, pc_out;
  logic [15:0] mem_wdata, acc_out;
  logic        mem_rd, mem_wr, ie_out, zero_out, sign_out;
  logic [1:0]  subcycle;

  always #2.5 clk = ~clk;

  isc_sequencer #(.SAVE_ADDR(SAVE), .HANDLER_ADDR(HND)) u_dut (
    .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc_out(pc_out), .acc_out(acc_out), .ie_out(ie_out),
    .zero_out(zero_out), .sign_out(sign_out), .subcycle(subcycle)
  );

  logic [15:0] dmem [0:1023];
  logic [15:0] mmem [0:1023];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= dmem[mem_addr[9:0]];
    if (mem_wr) dmem[mem_addr[9:0]] <= mem_wdata;
  end

  typedef struct {
    logic [1:0]  sub;
    bit          rd, wr;
    logic [11:0] addr;
    logic [15:0] wdata;
    logic [11:0] pc;
    logic [15:0] acc;
    bit          ie, z, s;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [11:0] m_pc;
  logic [15:0] m_acc;
  bit          m_ie, m_z, m_s;
  int          n_chk = 0, n_fail = 0, n_taken = 0, n_ignored = 0;

  function automatic bit irq_at(int c);
    return (c >= 5 && c <= 14) || (c >= 90 && c <= 110) || (c == 150) ||
           (c == 300) || (c >= 400 && c <= 415);
  endfunction

  function automatic logic [15:0] enc(int op, bit ind, int a);
    return {op[2:0], ind, a[11:0]};
  endfunction

  function automatic void emit(logic [1:0] sub, bit rd, bit wr, logic [11:0] a,
                               logic [15:0] wd, string tag);
    exp_t e;
    e.sub = sub; e.rd = rd; e.wr = wr; e.addr = a; e.wdata = wd;
    e.pc = m_pc; e.acc = m_acc; e.ie = m_ie; e.z = m_z; e.s = m_s; e.tag = tag;
    q.push_back(e);
  endfunction

  // instruction-level reference expanded into the per-cycle trace the requirements describe
  function automatic void build_model();
    m_pc = '0; m_acc = '0; m_ie = 0; m_z = 0; m_s = 0;
    while (q.size() < NCYC) begin
      logic [15:0] w, r;
      logic [11:0] ea;
      int op, dc;
      bit ie0;
      emit(0, 0, 0, 0, 0, "R2");
      emit(0, 1, 0, m_pc, 0, "R2");
      w = mmem[m_pc[9:0]];
      m_pc = m_pc + 12'd1;
      emit(0, 0, 0, 0, 0, "R2");
      emit(0, 0, 0, 0, 0, "R3");
      op = int'(w[15:13]);
      ea = w[11:0];
      if (w[12]) begin
        emit(1, 0, 0, 0, 0, "R4");
        emit(1, 1, 0, ea, 0, "R4");
        emit(1, 0, 0, 0, 0, "R4");
        ea = mmem[ea[9:0]][11:0];
      end
      ie0 = m_ie;
      case (op)
        0, 2: begin
          emit(2, 0, 0, 0, 0, "R5");
          emit(2, 1, 0, ea, 0, "R5");
          emit(2, 0, 0, 0, 0, "R5");
          emit(2, 0, 0, 0, 0, "R5");
          r = (op == 0) ? mmem[ea[9:0]] : m_acc + mmem[ea[9:0]];
          m_acc = r; m_z = (r == 16'd0); m_s = r[15];
        end
        1: begin
          emit(2, 0, 0, 0, 0, "R7");
          emit(2, 0, 1, ea, m_acc, "R7");
          mmem[ea[9:0]] = m_acc;
        end
        3: begin
          emit(2, 0, 0, 0, 0, "R8");
          m_pc = ea;
        end
        4: begin
          emit(2, 0, 0, 0, 0, "R12");
          emit(2, 1, 0, SAVE, 0, "R12");
          emit(2, 0, 0, 0, 0, "R12");
          emit(2, 0, 0, 0, 0, "R12");
          m_pc = mmem[SAVE[9:0]][11:0];
          m_ie = 1;
        end
        5: begin
          emit(2, 0, 0, 0, 0, "R9");
          m_ie = 1;
        end
        default: emit(2, 0, 0, 0, 0, "R9");
      endcase
      dc = q.size() - 1;
      if (irq_at(dc) && ie0) begin
        emit(3, 0, 0, 0, 0, "R10");
        emit(3, 0, 0, 0, 0, "R11");
        emit(3, 0, 1, SAVE, {4'd0, m_pc}, "R11");
        mmem[SAVE[9:0]] = {4'd0, m_pc};
        m_pc = HND; m_ie = 0;
        n_taken++;
      end else if (irq_at(dc)) begin
        n_ignored++;
      end
    end
  endfunction

  task automatic chk(string tag, string what, int cyc, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 1024; i++) dmem[i] = 16'd0;
    dmem[0]  = enc(0, 0, 'h200);  // load 5
    dmem[1]  = enc(2, 0, 'h201);  // add -5 -> zero
    dmem[2]  = enc(2, 0, 'h202);  // add 0x8000 -> sign
    dmem[3]  = enc(1, 0, 'h203);  // store
    dmem[4]  = enc(0, 1, 'h204);  // indirect load
    dmem[5]  = enc(3, 0, 7);      // jump over 6
    dmem[6]  = enc(0, 0, 'h200);
    dmem[7]  = enc(5, 0, 0);      // enable interrupts
    dmem[8]  = enc(1, 1, 'h206);  // indirect store
    dmem[9]  = enc(2, 0, 'h200);
    dmem[10] = enc(3, 1, 'h208);  // indirect jump to 12
    dmem[12] = enc(7, 0, 0);      // no-op
    dmem[13] = enc(0, 0, 'h203);
    dmem[14] = enc(3, 0, 14);     // idle loop
    dmem['h100] = enc(2, 0, 'h200);
    dmem['h101] = enc(1, 0, 'h20A);
    dmem['h102] = enc(4, 0, 0);   // return
    dmem['h200] = 16'd5;
    dmem['h201] = 16'hFFFB;
    dmem['h202] = 16'h8000;
    dmem['h204] = 16'h0205;
    dmem['h205] = 16'h1234;
    dmem['h206] = 16'h0207;
    dmem['h208] = 16'h000C;
    for (int i = 0; i < 1024; i++) mmem[i] = dmem[i];
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(NCYC * 10 + 2000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    load_program();
    build_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "pc", -1, 32'(pc_out), 0);
    chk("R1", "acc", -1, 32'(acc_out), 0);
    chk("R1", "flags", -1, {29'd0, ie_out, zero_out, sign_out}, 0);
    chk("R1", "strobes", -1, {30'd0, mem_rd, mem_wr}, 0);
    chk("R1", "subcycle", -1, 32'(subcycle), 0);
    rst = 1'b0;
    for (int c = 0; c < NCYC; c++) begin
      exp_t e;
      if (c > 0) @(negedge clk);
      irq = irq_at(c);
      e = q[c];
      if (c == 0) e.tag = "R1";
      chk(e.tag, "subcycle", c, 32'(subcycle), 32'(e.sub));
      chk(e.tag, "mem_rd", c, 32'(mem_rd), 32'(e.rd));
      chk(e.tag, "mem_wr", c, 32'(mem_wr), 32'(e.wr));
      if (e.rd || e.wr) chk(e.tag, "mem_addr", c, 32'(mem_addr), 32'(e.addr));
      if (e.wr) chk(e.tag, "mem_wdata", c, 32'(mem_wdata), 32'(e.wdata));
      chk(e.tag, "pc", c, 32'(pc_out), 32'(e.pc));
      chk(e.tag, "acc", c, 32'(acc_out), 32'(e.acc));
      chk(e.tag, "ie", c, 32'(ie_out), 32'(e.ie));
      chk("R6", "zero", c, 32'(zero_out), 32'(e.z));
      chk("R6", "sign", c, 32'(sign_out), 32'(e.s));
    end
    @(negedge clk);
    chk("R7", "mem[203]", NCYC, 32'(dmem['h203]), 32'(mmem['h203]));
    chk("R7", "mem[207]", NCYC, 32'(dmem['h207]), 32'(mmem['h207]));
    chk("R11", "mem[20A]", NCYC, 32'(dmem['h20A]), 32'(mmem['h20A]));
    chk("R11", "save word", NCYC, 32'(dmem[SAVE[9:0]]), 32'(mmem[SAVE[9:0]]));
    chk("R11", "entries taken", NCYC, 32'(n_taken > 0), 1);
    chk("R10", "requests masked", NCYC, 32'(n_ignored > 0), 1);
    summary();
    $finish;
  end
endmodule